// File: doc/BRIEF.md
# Halfword-to-Word AXI4 Write Packer

This block takes a stream of 16-bit values from a narrow producer and writes them to memory through a 32-bit AXI4 write master. It joins each pair of halfwords into one 32-bit beat and stores the beats in a small word FIFO. It issues an incrementing burst once the FIFO holds every beat of that burst. Every beat is full width (four bytes). A destination that begins or ends on an odd halfword is handled with byte strobes. Narrow transfer sizes are never used.

A session starts with a one-cycle `start` pulse while the block is idle. The pulse carries a halfword-aligned base address and a burst length (beats minus one). The producer then pushes halfwords with a valid/ready handshake and marks the final one with `in_last`. The block splits the data into bursts of the requested length. It shortens a burst where the next 4 KB page begins, where the FIFO depth would be exceeded, or where the data ends. Only one burst is in flight at a time. A failing write response raises a sticky error flag.

Top module: `hw2w_axi_packer`

## Requirements
- R1: Two halfwords accepted one after the other land in the same beat. The earlier one goes in bits 15:0 and the later one in bits 31:16.
- R2: Every write address handshake carries AWSIZE = 3'b010 and AWBURST = 2'b01 (incrementing). AWLEN is the beat count minus one. AWADDR and AWLEN do not change while AWVALID waits for AWREADY.
- R3: A burst is not issued until all of its beats are stored in the FIFO. The planned beat count is the smallest of: burst_len+1, FIFO_DEPTH, the words left before the next 4096-byte boundary, and the words left in the session.
- R4: When base address bit 1 is set, the first beat has WSTRB = 4'b1100. Its first halfword sits in bits 31:16 and bits 15:0 are zero.
- R5: When the data ends in the lower half of a beat, that final beat has WSTRB = 4'b0011 and bits 31:16 are zero. Every other beat has WSTRB = 4'b1111.
- R6: A burst carries exactly AWLEN+1 beats, and WLAST is high on the beat whose index (from 0) equals AWLEN. WDATA, WSTRB and WLAST are held while WREADY is low.
- R7: A new AW request is not raised until the B response of the previous burst has been taken. AWVALID is never high together with WVALID or BREADY.
- R8: The first AWADDR is the base address with bits 1:0 cleared. Each later AWADDR is the previous one plus 4 × (AWLEN+1). Base address bit 0 must be zero.
- R9: No burst crosses a 4096-byte boundary.
- R10: A BRESP other than 2'b00 sets err_flag. err_flag stays set until the next accepted start, which clears it.
- R11: in_ready is low whenever the FIFO holds FIFO_DEPTH words.
- R12: After reset, busy, in_ready, AWVALID and WVALID are low. After in_last is accepted, in_ready stays low, the remaining words go out in a final (possibly shorter) burst, and busy falls when that burst's response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a session (used only while busy is low) |
| base_addr | input | ADDR_W | Halfword-aligned byte address of the first halfword |
| burst_len | input | LEN_W | Requested beats per burst minus one |
| busy | output | 1 | Session in progress |
| err_flag | output | 1 | Sticky error response flag |
| in_valid | input | 1 | Halfword valid |
| in_ready | output | 1 | Halfword accepted when high with in_valid |
| in_data | input | 16 | Halfword value |
| in_last | input | 1 | Marks the final halfword of the session |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Burst start address |
| m_awlen | output | LEN_W | Beats minus one |
| m_awsize | output | 3 | Transfer size, always 4 bytes |
| m_awburst | output | 2 | Burst type, always incrementing |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Byte strobes |
| m_wlast | output | 1 | Final beat of the burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |

## Verification
The assertions assume the following about the environment:
- base_addr is even whenever start is raised.
- The slave answers each burst with exactly one response, and only after that burst's last data beat.
- in_last is raised once per session.

The stimulus keeps to these rules. It always uses even base addresses and pulses start only after busy has fallen. Its slave model raises one B response per observed WLAST handshake. It sweeps page-edge and interior bases, both halfword offsets, burst lengths from 0 to 15 and session lengths from 1 to 12. It also runs one session in which the address channel is held off so that the FIFO fills.

// File: rtl/hw2w_pkg.sv
package hw2w_pkg;
  localparam int HALF_W   = 16;
  localparam int WORD_W   = 32;
  localparam int STRB_W   = WORD_W / 8;
  localparam int PAGE_WORDS = 1024;

  localparam logic [2:0] AXSIZE_WORD = 3'b010;
  localparam logic [1:0] AXBURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [STRB_W-1:0] strb;
  } beat_t;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_PLAN,
    BS_ADDR,
    BS_DATA,
    BS_RESP
  } bstate_t;
endpackage

// File: rtl/hw2w_joiner.sv
module hw2w_joiner
  import hw2w_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sess_begin,
  input  logic              begin_upper,
  input  logic              sess_active,
  input  logic              fifo_full,
  input  logic              in_valid,
  input  logic [HALF_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              push,
  output beat_t             push_beat,
  output logic              tail_done
);
  logic              upper_q;
  logic              lo_vld_q;
  logic [HALF_W-1:0] lo_q;
  logic              ended_q;
  logic              take;

  assign in_ready  = sess_active && !ended_q && !fifo_full;
  assign take      = in_valid && in_ready;
  assign push      = take && (upper_q || in_last);
  assign tail_done = ended_q;

  always_comb begin
    if (upper_q) begin
      push_beat.data = {in_data, (lo_vld_q ? lo_q : {HALF_W{1'b0}})};
      push_beat.strb = {2'b11, (lo_vld_q ? 2'b11 : 2'b00)};
    end else begin
      push_beat.data = {{HALF_W{1'b0}}, in_data};
      push_beat.strb = 4'b0011;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q  <= 1'b0;
      lo_vld_q <= 1'b0;
      lo_q     <= '0;
      ended_q  <= 1'b0;
    end else if (sess_begin) begin
      upper_q  <= begin_upper;
      lo_vld_q <= 1'b0;
      ended_q  <= 1'b0;
    end else if (take) begin
      if (upper_q) begin
        upper_q  <= 1'b0;
        lo_vld_q <= 1'b0;
      end else if (!in_last) begin
        lo_q     <= in_data;
        lo_vld_q <= 1'b1;
        upper_q  <= 1'b1;
      end
      if (in_last) ended_q <= 1'b1;
    end
  end

  // R12: no halfword is taken once the final one has been stored
  p_closed_after_tail_r12: assert property (@(posedge clk) disable iff (rst)
    ended_q && !sess_begin |=> !take);
endmodule

// File: rtl/hw2w_fifo.sv
module hw2w_fifo
  import hw2w_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  beat_t            push_beat,
  input  logic             pop,
  output beat_t            rd_beat,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  beat_t            mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_beat;
  end

  always_ff @(posedge clk) begin
    if (rst)      rd_beat <= '0;
    else if (pop) rd_beat <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt_q != '0);
endmodule

// File: rtl/hw2w_burst.sv
module hw2w_burst
  import hw2w_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WA_W  = ADDR_W - 2,
  localparam int BC_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WA_W-1:0]   base_word,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              tail_done,
  output logic              sess_begin,
  output logic              busy,
  output logic              err_flag,
  output logic              pop,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [LEN_W-1:0]  awlen,
  output logic              wvalid,
  input  logic              wready,
  output logic              wlast,
  input  logic              bvalid,
  output logic              bready,
  input  logic [1:0]        bresp
);
  bstate_t          st;
  logic [WA_W-1:0]  waddr_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] awlen_q;
  logic             awvalid_q;
  logic             wvalid_q;
  logic             wlast_q;
  logic [LEN_W:0]   ld_cnt;
  logic             bready_q;
  logic             err_q;

  logic [BC_W-1:0]  room;
  logic [BC_W-1:0]  want;
  logic [BC_W-1:0]  avail;
  logic [BC_W-1:0]  plan_beats;

  assign sess_begin = start && (st == BS_IDLE);
  assign busy       = (st != BS_IDLE);
  assign err_flag   = err_q;
  assign awvalid    = awvalid_q;
  assign awaddr     = {waddr_q, 2'b00};
  assign awlen      = awlen_q;
  assign wvalid     = wvalid_q;
  assign wlast      = wlast_q;
  assign bready     = bready_q;

  always_comb begin
    room  = BC_W'(PAGE_WORDS) - BC_W'(waddr_q[9:0]);
    avail = BC_W'(fifo_count);
    want  = BC_W'(len_q) + 1'b1;
    if (room < want) want = room;
    if (BC_W'(DEPTH) < want) want = BC_W'(DEPTH);
    if (avail >= want)                   plan_beats = want;
    else if (tail_done && avail != '0)   plan_beats = avail;
    else                                 plan_beats = '0;
  end

  assign pop = (st == BS_DATA) && (!wvalid_q || wready) &&
               !(wvalid_q && wlast_q) && (ld_cnt <= {1'b0, awlen_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= BS_IDLE;
      waddr_q   <= '0;
      len_q     <= '0;
      awlen_q   <= '0;
      awvalid_q <= 1'b0;
      wvalid_q  <= 1'b0;
      wlast_q   <= 1'b0;
      ld_cnt    <= '0;
      bready_q  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      case (st)
        BS_IDLE: begin
          if (start) begin
            waddr_q <= base_word;
            len_q   <= burst_len;
            err_q   <= 1'b0;
            st      <= BS_PLAN;
          end
        end
        BS_PLAN: begin
          if (plan_beats != '0) begin
            awlen_q   <= LEN_W'(plan_beats - 1'b1);
            awvalid_q <= 1'b1;
            st        <= BS_ADDR;
          end
        end
        BS_ADDR: begin
          if (awready) begin
            awvalid_q <= 1'b0;
            ld_cnt    <= '0;
            st        <= BS_DATA;
          end
        end
        BS_DATA: begin
          if (wvalid_q && wready && wlast_q) begin
            wvalid_q <= 1'b0;
            wlast_q  <= 1'b0;
            bready_q <= 1'b1;
            waddr_q  <= waddr_q + WA_W'(awlen_q) + 1'b1;
            st       <= BS_RESP;
          end else if (pop) begin
            wvalid_q <= 1'b1;
            wlast_q  <= (ld_cnt == {1'b0, awlen_q});
            ld_cnt   <= ld_cnt + 1'b1;
          end
        end
        BS_RESP: begin
          if (bvalid) begin
            bready_q <= 1'b0;
            if (bresp != RESP_OKAY) err_q <= 1'b1;
            st <= (tail_done && fifo_count == '0) ? BS_IDLE : BS_PLAN;
          end
        end
        default: st <= BS_IDLE;
      endcase
    end
  end

  p_aw_hold_r2: assert property (@(posedge clk) disable iff (rst)
    awvalid_q && !awready |=> awvalid_q && $stable(waddr_q) && $stable(awlen_q));
  p_w_hold_r6: assert property (@(posedge clk) disable iff (rst)
    wvalid_q && !wready |=> wvalid_q && $stable(wlast_q));
  p_one_outstanding_r7: assert property (@(posedge clk) disable iff (rst)
    awvalid_q |-> !wvalid_q && !bready_q);
  p_page_kept_r9: assert property (@(posedge clk) disable iff (rst)
    awvalid_q |-> (BC_W'(waddr_q[9:0]) + BC_W'(awlen_q)) < BC_W'(PAGE_WORDS));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_q && !sess_begin |=> err_q);
endmodule

// File: rtl/hw2w_axi_packer.sv
module hw2w_axi_packer
  import hw2w_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  burst_len,
  output logic              busy,
  output logic              err_flag,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_data,
  input  logic              in_last,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [LEN_W-1:0]  m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [31:0]       m_wdata,
  output logic [3:0]        m_wstrb,
  output logic              m_wlast,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [1:0]        m_bresp
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             sess_begin;
  logic             push;
  logic             pop;
  logic             fifo_full;
  logic             tail_done;
  logic [CNT_W-1:0] fifo_count;
  beat_t            push_beat;
  beat_t            rd_beat;

  assign m_awsize  = AXSIZE_WORD;
  assign m_awburst = AXBURST_INCR;
  assign m_wdata   = rd_beat.data;
  assign m_wstrb   = rd_beat.strb;

  hw2w_joiner u_join (
    .clk         (clk),
    .rst         (rst),
    .sess_begin  (sess_begin),
    .begin_upper (base_addr[1]),
    .sess_active (busy),
    .fifo_full   (fifo_full),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_last     (in_last),
    .in_ready    (in_ready),
    .push        (push),
    .push_beat   (push_beat),
    .tail_done   (tail_done)
  );

  hw2w_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_beat (push_beat),
    .pop       (pop),
    .rd_beat   (rd_beat),
    .count     (fifo_count),
    .full      (fifo_full)
  );

  hw2w_burst #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(FIFO_DEPTH)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .base_word  (base_addr[ADDR_W-1:2]),
    .burst_len  (burst_len),
    .fifo_count (fifo_count),
    .tail_done  (tail_done),
    .sess_begin (sess_begin),
    .busy       (busy),
    .err_flag   (err_flag),
    .pop        (pop),
    .awvalid    (m_awvalid),
    .awready    (m_awready),
    .awaddr     (m_awaddr),
    .awlen      (m_awlen),
    .wvalid     (m_wvalid),
    .wready     (m_wready),
    .wlast      (m_wlast),
    .bvalid     (m_bvalid),
    .bready     (m_bready),
    .bresp      (m_bresp)
  );

  p_base_even_r8: assert property (@(posedge clk) disable iff (rst)
    start && !busy |-> !base_addr[0]);
  p_stall_full_r11: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !in_ready);
endmodule

// File: tb/hw2w_axi_packer_tb_top.sv
`timescale 1ns/1ps
module hw2w_axi_packer_tb_top;
  localparam int TB_DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] base_addr;
  logic [7:0]  burst_len;
  logic        busy, err_flag;
  logic        in_valid, in_ready, in_last;
  logic [15:0] in_data;
  logic        m_awvalid, m_awready;
  logic [31:0] m_awaddr;
  logic [7:0]  m_awlen;
  logic [2:0]  m_awsize;
  logic [1:0]  m_awburst;
  logic        m_wvalid, m_wready, m_wlast;
  logic [31:0] m_wdata;
  logic [3:0]  m_wstrb;
  logic        m_bvalid, m_bready;
  logic [1:0]  m_bresp;

  always #2 clk = ~clk;

  hw2w_axi_packer #(.ADDR_W(32), .LEN_W(8), .FIFO_DEPTH(TB_DEPTH)) dut_i (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .burst_len(burst_len), .busy(busy), .err_flag(err_flag),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
    .m_awburst(m_awburst), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp)
  );

  int n_chk = 0;
  int n_fail = 0;

  // session model state
  int c_seed, c_base, c_nhw, c_len, c_off, c_nwords;
  int exp_addr, words_left, issued, wb, acc, cur_burst, beat_in;
  int outstanding, b_owed, cyc;
  bit last_acc, b_hs, err_mode, aw_gate;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] hval(input int i);
    return 16'((c_seed * 257) + (i * 4951) + 3855);
  endfunction

  function automatic logic [35:0] exp_word(input int k);
    logic [31:0] d = '0;
    logic [3:0]  s = '0;
    for (int j = 0; j < 2; j++) begin
      int i = 2 * k + j - c_off;
      if (i >= 0 && i < c_nhw) begin
        d[16*j +: 16] = hval(i);
        s[2*j +: 2]   = 2'b11;
      end
    end
    return {s, d};
  endfunction

  // slave model
  initial begin
    m_awready = 1'b0; m_wready = 1'b0; m_bvalid = 1'b0; m_bresp = 2'b00;
    forever begin
      @(posedge clk); #1;
      cyc++;
      m_awready = aw_gate && (cyc % 3 != 1);
      m_wready  = (cyc % 4 != 2);
      if (b_hs) begin
        m_bvalid = 1'b0;
        b_hs = 1'b0;
      end else if (!m_bvalid && b_owed > 0) begin
        m_bvalid = 1'b1;
        m_bresp  = err_mode ? 2'b10 : 2'b00;
        b_owed--;
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (m_awvalid && m_awready) begin
          int room, expb, capb, formed;
          room = (4096 - (exp_addr % 4096)) / 4;
          capb = c_len + 1;
          if (TB_DEPTH < capb) capb = TB_DEPTH;
          expb = capb;
          if (room < expb) expb = room;
          if (words_left < expb) expb = words_left;
          formed = last_acc ? c_nwords : (c_off + acc) / 2;
          chk(int'(m_awaddr) == exp_addr, "R8", "awaddr", m_awaddr, exp_addr);
          chk(int'(m_awlen) == expb - 1, (room < capb) ? "R9" : "R2", "awlen",
              m_awlen, expb - 1);
          chk(m_awsize == 3'b010 && m_awburst == 2'b01, "R2", "size/burst",
              {m_awsize, m_awburst}, 5'b01001);
          chk(outstanding == 0, "R7", "outstanding at AW", outstanding, 0);
          chk(formed >= issued + expb, "R3", "words stored before AW",
              formed, issued + expb);
          cur_burst = expb; beat_in = 0;
          exp_addr += 4 * expb; words_left -= expb; issued += expb;
          outstanding = 1;
        end
        if (m_wvalid && m_wready) begin
          logic [35:0] ew;
          string rq;
          ew = exp_word(wb);
          if (wb == 0 && c_off == 1) rq = "R4";
          else if (wb == c_nwords - 1 && ((c_off + c_nhw) % 2 == 1)) rq = "R5";
          else rq = "R1";
          chk(m_wdata == ew[31:0], rq, "wdata", m_wdata, ew[31:0]);
          chk(m_wstrb == ew[35:32], rq, "wstrb", m_wstrb, ew[35:32]);
          chk(m_wlast == (beat_in == cur_burst - 1), "R6", "wlast", m_wlast,
              beat_in == cur_burst - 1);
          beat_in++; wb++;
          if (m_wlast) b_owed++;
        end
        if (m_bvalid && m_bready) begin
          outstanding = 0;
          b_hs = 1'b1;
        end
        if (in_valid && in_ready) begin
          acc++;
          if (in_last) last_acc = 1'b1;
        end
      end
    end
  end

  task automatic send_hw(input int i, input int maxw, output bit ok);
    in_valid = 1'b1; in_data = hval(i); in_last = (i == c_nhw - 1); ok = 1'b0;
    for (int w = 0; w < maxw; w++) begin
      @(negedge clk);
      if (in_ready) begin
        ok = 1'b1;
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_case(input int base, input int nhw, input int len,
                          input bit err, input bit hold);
    bit ok, idle;
    c_seed++; c_base = base; c_nhw = nhw; c_len = len;
    c_off = (base >> 1) & 1;
    c_nwords = (c_off + nhw + 1) / 2;
    exp_addr = base & ~3; words_left = c_nwords; issued = 0; wb = 0;
    acc = 0; last_acc = 1'b0; err_mode = err; cur_burst = 0; beat_in = 0;
    aw_gate = !hold;
    start = 1'b1; base_addr = 32'(base); burst_len = 8'(len);
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < nhw; i++) begin
      send_hw(i, hold ? 30 : 5000, ok);
      if (!ok && hold) begin
        @(negedge clk);
        chk(acc == 2 * TB_DEPTH && !in_ready, "R11", "halfwords taken at full",
            acc, 2 * TB_DEPTH);
        @(posedge clk); #1;
        aw_gate = 1'b1;
        send_hw(i, 5000, ok);
      end
      if (i % 4 == 3) begin
        @(posedge clk); #1;
      end
    end
    idle = 1'b0;
    for (int w = 0; w < 3000; w++) begin
      @(negedge clk);
      if (!busy) begin
        idle = 1'b1;
        break;
      end
    end
    chk(idle && !in_ready, "R12", "session ends idle", {idle, in_ready}, 2'b10);
    chk(words_left == 0, "R12", "words left", words_left, 0);
    chk(wb == c_nwords, "R6", "beats written", wb, c_nwords);
    chk(err_flag == err, "R10", "err_flag", err_flag, err);
    chk(outstanding == 0, "R7", "outstanding at end", outstanding, 0);
    @(posedge clk); #1;
  endtask

  initial begin
    int bases[5];
    int lens[5];
    bases = '{32'h100, 32'h102, 32'hFF8, 32'hFFA, 32'h1FF2};
    lens  = '{0, 1, 3, 7, 15};
    rst = 1'b1; start = 1'b0; base_addr = '0; burst_len = '0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; aw_gate = 1'b1;
    c_seed = 0; b_owed = 0; b_hs = 1'b0; outstanding = 0; cyc = 0;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!busy && !in_ready && !m_awvalid && !m_wvalid && !err_flag, "R12",
        "reset state", {busy, in_ready, m_awvalid, m_wvalid, err_flag}, 0);
    @(posedge clk); #1;
    for (int b = 0; b < 5; b++)
      for (int l = 0; l < 5; l++)
        for (int n = 1; n <= 12; n++)
          run_case(bases[b], n, lens[l], (n % 5 == 3), 1'b0);
    run_case(32'h200, 24, 7, 1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule